// File: doc/BRIEF.md
# Guarded Tapped Delay Line

A synchronous, non-inverting delay line built from a cascade of one-cycle storage stages. An address picks which stage drives the output through a registered multiplexer. A level driven on `din` therefore reappears on `dout` after the selected number of steps plus a fixed inherent latency of two register stages. Rising and falling edges are shifted alike.

Changing the selected stage while transitions are still moving along the cascade could expose old and new edges side by side and create spurious output pulses. A guard therefore holds every address request as pending. It applies the request only once the sampled input has shown no change for as many cycles as the longest delay, so that the whole cascade holds a single level. After the switch, a settling window keeps the busy flag raised. A caller writes an address with `req_stb`, waits for `busy` to fall, and from then on can rely on `dout` being delayed by exactly the applied amount.

Top module: `tap_delay_line`

## Requirements
- R1: After reset, `dout` is 0, `cur_addr` is 0, `busy` is 0, and every storage stage holds 0.
- R2: With an applied address A (0 to 2**ADDR_W-1), the level presented on `din` before clock edge k appears on `dout` just after edge k+A+1. That is A+2 register stages in total, so step 0 has two cycles of latency.
- R3: The output is never inverted, and rising and falling edges are delayed by the same amount, so a pulse one cycle wide comes out one cycle wide.
- R4: An edge with `req_stb` high stores `req_addr` as the pending address, and `busy` is high just after that edge.
- R5: A pending address becomes `cur_addr` at edge L+2**ADDR_W. L is the last edge at which the sampled `din` differed from the level sampled at the edge before it. Reset counts as such an edge, and the sampled level before the first edge is 0. No address is applied on an edge where `req_stb` is high.
- R6: While a request is pending and the input keeps changing, `cur_addr` and the delay seen on `dout` keep their old values.
- R7: A second request made while one is pending replaces the pending address, so only the last one is applied.
- R8: `busy` stays high for the edge that applies an address and the one after it, and drops after the second edge following the apply, unless a new request is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 1 | Data bit to be delayed |
| req_addr | input | ADDR_W | Requested delay step |
| req_stb | input | 1 | Update request, one cycle high per request |
| dout | output | 1 | Delayed copy of `din` |
| cur_addr | output | ADDR_W | Currently applied delay step |
| busy | output | 1 | High while a request is pending or the new delay is settling |

## Verification
The delay path is driven with pseudo-random bit streams at step 0, at a middle step and at the largest step. This separates an off-by-one in the tap selection from an error in the inherent latency. Bursts of single-cycle pulses of both polarities show whether rising and falling edges are treated alike. The guard is tried with a request made right after reset, with a request made after a long idle stretch, and with two requests made while the input keeps toggling. These cases show whether the idle count starts from reset, whether it restarts on every input change, and whether the last request wins. The exact edge at which `cur_addr` changes and at which `busy` falls is checked in each case.

// File: rtl/tdl_pkg.sv
package tdl_pkg;

  // Idle counter update: restart on a sampled input change, else count up and saturate.
  function automatic int idle_next(int cnt, logic chg, int limit);
    if (chg) return 0;
    if (cnt >= limit) return limit;
    return cnt + 1;
  endfunction

  // Settling counter update: load on apply, else count down to zero.
  function automatic int settle_next(int cnt, logic load, int init);
    if (load) return init;
    if (cnt > 0) return cnt - 1;
    return 0;
  endfunction

endpackage

// File: rtl/tdl_chain.sv
module tdl_chain #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          din,
  input  logic [AW-1:0] sel,
  output logic          stage0,
  output logic          dout
);
  localparam int TAPS = 1 << AW;

  logic [TAPS-1:0] stg;
  logic            dout_q;

  // Cascade: bit 0 takes the input, each further bit takes its neighbour.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg    <= '0;
      dout_q <= 1'b0;
    end else begin
      stg    <= {stg[TAPS-2:0], din};
      dout_q <= stg[sel];
    end
  end

  assign stage0 = stg[0];
  assign dout   = dout_q;
endmodule

// File: rtl/tdl_guard.sv
module tdl_guard #(
  parameter int AW     = 8,
  parameter int SETTLE = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          din,
  input  logic          stage0,
  input  logic          req_stb,
  input  logic [AW-1:0] req_addr,
  output logic [AW-1:0] cur_addr,
  output logic          busy,
  output logic          pend_o,
  output logic          idle_full_o,
  output logic          apply_o,
  output logic          chg_o
);
  import tdl_pkg::*;

  localparam int IDLE_MAX = (1 << AW) - 1;
  localparam int SW       = $clog2(SETTLE + 1);

  logic [AW-1:0] idle_cnt;
  logic [AW-1:0] pend_addr;
  logic [AW-1:0] addr_q;
  logic [SW-1:0] settle_cnt;
  logic          pend;
  logic          chg;
  logic          idle_full;
  logic          apply;

  assign chg       = (din != stage0);
  assign idle_full = (int'(idle_cnt) == IDLE_MAX);
  assign apply     = pend && idle_full && !req_stb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_cnt   <= '0;
      pend       <= 1'b0;
      pend_addr  <= '0;
      addr_q     <= '0;
      settle_cnt <= '0;
    end else begin
      idle_cnt   <= AW'(idle_next(int'(idle_cnt), chg, IDLE_MAX));
      settle_cnt <= SW'(settle_next(int'(settle_cnt), apply, SETTLE));
      if (req_stb) begin
        pend      <= 1'b1;
        pend_addr <= req_addr;
      end else if (apply) begin
        pend <= 1'b0;
      end
      if (apply) addr_q <= pend_addr;
    end
  end

  assign cur_addr    = addr_q;
  assign busy        = pend || (settle_cnt != '0);
  assign pend_o      = pend;
  assign idle_full_o = idle_full;
  assign apply_o     = apply;
  assign chg_o       = chg;
endmodule

// File: rtl/tap_delay_line.sv
module tap_delay_line #(
  parameter int ADDR_W = 8,
  parameter int SETTLE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              din,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_stb,
  output logic              dout,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              busy
);
  logic              w_stage0;
  logic [ADDR_W-1:0] w_sel;
  logic              w_pend;
  logic              w_idle_full;
  logic              w_apply;
  logic              w_chg;

  tdl_chain #(.AW(ADDR_W)) u_chain (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    (din),
    .sel    (w_sel),
    .stage0 (w_stage0),
    .dout   (dout)
  );

  tdl_guard #(.AW(ADDR_W), .SETTLE(SETTLE)) u_guard (
    .clk         (clk),
    .rst_n       (rst_n),
    .din         (din),
    .stage0      (w_stage0),
    .req_stb     (req_stb),
    .req_addr    (req_addr),
    .cur_addr    (w_sel),
    .busy        (busy),
    .pend_o      (w_pend),
    .idle_full_o (w_idle_full),
    .apply_o     (w_apply),
    .chg_o       (w_chg)
  );

  assign cur_addr = w_sel;
endmodule

// File: rtl/tdl_props.sv
module tdl_props #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_stb,
  input logic          busy,
  input logic [AW-1:0] cur_addr,
  input logic          pend,
  input logic          idle_full,
  input logic          apply,
  input logic          chg
);
  // R4: a request raises busy on the following cycle
  a_r4_stb_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    req_stb |=> busy);

  // R5: the applied address only moves after a full idle window
  a_r5_apply_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_addr) |-> $past(idle_full));

  // R6: while pending and not yet idle long enough, the address holds
  a_r6_hold_while_active: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !idle_full) |=> $stable(cur_addr));

  // R8: the apply edge is followed by a busy settling cycle
  a_r8_settle_busy: assert property (@(posedge clk) disable iff (!rst_n)
    apply |=> busy);

  // R8: with nothing pending or settling, the address stays put
  a_r8_quiet_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(cur_addr));

  // R5: a change seen on the input restarts the idle window
  a_r5_change_clears_idle: assert property (@(posedge clk) disable iff (!rst_n)
    chg |=> !idle_full);
endmodule

bind tap_delay_line tdl_props #(.AW(ADDR_W)) u_props (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_stb   (req_stb),
  .busy      (busy),
  .cur_addr  (cur_addr),
  .pend      (w_pend),
  .idle_full (w_idle_full),
  .apply     (w_apply),
  .chg       (w_chg)
);

// File: tb/sim_tap_delay_line.sv
module sim_tap_delay_line;
  localparam int AW    = 8;
  localparam int TAPS  = 1 << AW;
  localparam int LIMIT = 150000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          din = 1'b0;
  logic          req_stb = 1'b0;
  logic [AW-1:0] req_addr = '0;
  wire           dout;
  wire  [AW-1:0] cur_addr;
  wire           busy;

  tap_delay_line #(.ADDR_W(AW), .SETTLE(2)) u0 (
    .clk(clk), .rst_n(rst_n), .din(din), .req_addr(req_addr),
    .req_stb(req_stb), .dout(dout), .cur_addr(cur_addr), .busy(busy)
  );

  always #4 clk = ~clk;

  int ecnt = 0;
  always @(posedge clk) if (rst_n) ecnt <= ecnt + 1;

  int total = 0;
  int bad = 0;

  typedef struct { int due; logic val; } exp_t;
  exp_t  sbq[$];
  int    exp_a = 0;
  bit    sb_on = 1'b0;
  string sb_tag = "R2";
  logic  last_drv = 1'b0;
  int    last_chg_edge = 0;
  logic [15:0] lf = 16'hACE1;

  task automatic chk(string req, int act, int exp, string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d (edge %0d)", req, what, act, exp, ecnt);
    end
  endtask

  // Driver: present one bit for the next edge; push the expected output.
  task automatic step(logic v);
    @(negedge clk);
    din = v;
    if (v != last_drv) last_chg_edge = ecnt + 1;
    last_drv = v;
    if (sb_on) sbq.push_back('{ecnt + 1 + exp_a + 1, v});
  endtask

  task automatic hold(int n);
    for (int i = 0; i < n; i++) step(last_drv);
  endtask

  task automatic rnd_traffic(int n);
    for (int i = 0; i < n; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[0]);
    end
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      step(~last_drv);
      step(~last_drv);
      hold(i % 3);
    end
  endtask

  // Request: strobe sampled at the next edge; returns at the negedge after it.
  task automatic strobe(logic [AW-1:0] a);
    @(negedge clk);
    req_stb = 1'b1;
    req_addr = a;
    din = last_drv;
    if (sb_on) sbq.push_back('{ecnt + 1 + exp_a + 1, last_drv});
    @(negedge clk);
    req_stb = 1'b0;
    din = last_drv;
    if (sb_on) sbq.push_back('{ecnt + 1 + exp_a + 1, last_drv});
  endtask

  task automatic wait_to(int n);
    while (ecnt < n) @(negedge clk);
  endtask

  task automatic drain();
    sb_on = 1'b0;
    while (sbq.size() > 0) hold(1);
  endtask

  // Monitor: pop every expected item due at this edge and compare.
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].due <= ecnt) begin
      exp_t e;
      e = sbq.pop_front();
      chk(sb_tag, int'(dout), int'(e.val), "delayed bit");
    end
  end

  // Watchdog
  always @(negedge clk) begin
    if (ecnt > LIMIT) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected<=%0d", ecnt, LIMIT);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int s;
    int lc;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values, edge 0
    chk("R1", int'(dout), 0, "dout");
    chk("R1", int'(cur_addr), 0, "cur_addr");
    chk("R1", int'(busy), 0, "busy");

    // R4/R5 after reset: request at edge 3, idle count starts at zero
    wait_to(1);
    strobe(8'd5);
    chk("R4", int'(busy), 1, "busy after strobe");
    chk("R1", int'(dout), 0, "dout with cleared stages");
    wait_to(TAPS - 1);
    chk("R5", int'(cur_addr), 0, "addr before idle window ends");
    wait_to(TAPS);
    chk("R5", int'(cur_addr), 5, "addr at edge 256");
    wait_to(TAPS + 1);
    chk("R8", int'(busy), 1, "busy one edge after apply");
    wait_to(TAPS + 2);
    chk("R8", int'(busy), 0, "busy two edges after apply");

    // R2: random traffic at step 5
    exp_a = 5; sb_tag = "R2"; sb_on = 1'b1;
    rnd_traffic(200);
    sb_tag = "R3";
    pulses(20);
    drain();

    // Request after a long idle stretch: applied on the next edge
    hold(TAPS + 4);
    strobe(8'd0);
    s = ecnt;
    chk("R4", int'(busy), 1, "busy after strobe");
    chk("R5", int'(cur_addr), 5, "addr on strobe edge");
    wait_to(s + 1);
    chk("R5", int'(cur_addr), 0, "addr one edge after strobe");
    wait_to(s + 2);
    chk("R8", int'(busy), 1, "busy settling");
    wait_to(s + 3);
    chk("R8", int'(busy), 0, "busy released");

    // R2 at step 0
    exp_a = 0; sb_tag = "R2"; sb_on = 1'b1;
    rnd_traffic(150);
    sb_tag = "R3";
    pulses(15);
    drain();

    // Move to the largest step
    hold(TAPS + 4);
    strobe(8'(TAPS - 1));
    wait_to(ecnt + 3);
    chk("R5", int'(cur_addr), TAPS - 1, "addr max step");
    exp_a = TAPS - 1; sb_tag = "R2"; sb_on = 1'b1;
    rnd_traffic(300);

    // R6/R7: requests while the input keeps toggling
    strobe(8'd10);
    rnd_traffic(40);
    strobe(8'd20);
    rnd_traffic(60);
    chk("R6", int'(cur_addr), TAPS - 1, "addr held while toggling");
    chk("R6", int'(busy), 1, "busy while pending");
    step(~last_drv);
    lc = last_chg_edge;
    sb_on = 1'b0;
    wait_to(lc + TAPS - 1);
    chk("R6", int'(cur_addr), TAPS - 1, "addr just before idle window ends");
    wait_to(lc + TAPS);
    chk("R7", int'(cur_addr), 20, "last request applied");
    wait_to(lc + TAPS + 2);
    chk("R8", int'(busy), 0, "busy released after last request");
    while (sbq.size() > 0) hold(1);

    // R2/R3 at step 20
    exp_a = 20; sb_tag = "R3"; sb_on = 1'b1;
    pulses(25);
    sb_tag = "R2";
    rnd_traffic(150);
    drain();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule